// File: doc/BRIEF.md
# E1 Remote Alarm Interrupt Unit

This block sits behind an E1 frame aligner and watches the stream that is already aligned. For each received frame it gets a strobe, a flag that says whether the frame carries the frame alignment signal (FAS), and the sampled A bit. From the A bits of non-FAS frames it keeps a filtered remote (yellow) alarm state. The state changes only when two non-FAS frames in a row agree. Because FAS and non-FAS frames alternate, a change takes three 125 us frames, which is 375 us.

The block also collects interrupt events. Other logic supplies two level inputs: the out-of-frame state and the CAS multiframe yellow state. A change of either level, in either direction, is one event. Each line code violation pulse is also one event. An event sets a sticky status bit only when its enable bit is 1. The single interrupt line is high while any status bit is set. Software uses a two-address register port. Address 0 is the enable register, and bit 7 of it reads back the alarm state. Address 1 is the status register, and reading it clears it.

Top module: `e1_rai_irq`

## Requirements
- R1: `rai_state` becomes 1 on the clock edge that accepts a non-FAS frame whose A bit is 1, if the previous non-FAS frame also had A bit 1. A single non-FAS frame with A=1, or alternating A values, never declares the alarm. The reset value is 0.
- R2: `rai_state` becomes 0 on the clock edge that accepts a non-FAS frame whose A bit is 0, if the previous non-FAS frame also had A bit 0.
- R3: Frames with `frm_is_fas`=1 change neither the alarm state nor the remembered A bit. A FAS frame between two agreeing non-FAS frames does not break their run.
- R4: Address 0 (`reg_sel`=0) reads as follows. Bit 7 is `rai_state` and is read-only. Bits 6, 1 and 0 read 0. Bits 5, 4, 3 and 2 are writable, reset to 0 and read back what was written. Bit 4 must be kept at 0.
- R5: When enable bit 2 is 1, every rise and every fall of `oof_lvl` sets status bit 2. When enable bit 2 is 0, a change of `oof_lvl` leaves status bit 2 clear.
- R6: When enable bit 5 is 1, every rise and every fall of `mfyel_lvl` sets status bit 5.
- R7: When enable bit 3 is 1, each clock cycle with `lcv_pulse`=1 sets status bit 3. The bit stays set until it is read.
- R8: Address 1 (`reg_sel`=1) reads the status register, with bits 5, 3 and 2 as above and all other bits 0. A read clears the status register at the following edge. An event that arrives in the same cycle as the read is kept and shows on the next read.
- R9: `irq` is active high. It is 1 exactly while at least one status bit is set, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_stb | input | 1 | One-cycle strobe per received frame |
| frm_is_fas | input | 1 | 1 when the strobed frame is a FAS frame |
| frm_a_bit | input | 1 | A bit of the strobed frame |
| oof_lvl | input | 1 | Out-of-frame state from the aligner |
| mfyel_lvl | input | 1 | CAS multiframe yellow state |
| lcv_pulse | input | 1 | One-cycle line code violation event |
| reg_sel | input | 1 | 0 selects the enable register, 1 selects the status register |
| reg_wr | input | 1 | Write strobe (enable register only) |
| reg_rd | input | 1 | Read strobe; clears the status register when `reg_sel`=1 |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, combinational from `reg_sel` |
| rai_state | output | 1 | Filtered remote alarm state |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two things can meet in one cycle: the clear caused by a status read, and a new event arriving. The bench pulses `lcv_pulse` in the same cycle that it reads address 1. That read must return the old contents, and the following read must show bit 3 set, which proves the new event won over the clear. A second overlap happens when the out-of-frame change and a violation arrive together. Both status bits must appear in a single read, and `irq` must stay high until that read.

// File: rtl/e1_rai_irq.sv
module e1_rai_irq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_stb,
  input  logic          frm_is_fas,
  input  logic          frm_a_bit,
  input  logic          oof_lvl,
  input  logic          mfyel_lvl,
  input  logic          lcv_pulse,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          rai_state,
  output logic          irq
);
  localparam int B_RAI = 7;
  localparam int B_MF  = 5;
  localparam int B_RSV = 4;
  localparam int B_LCV = 3;
  localparam int B_OOF = 2;

  logic en_mf, en_rsv, en_lcv, en_oof;
  logic last_a, rai_q;
  logic oof_q, mf_q;
  logic st_mf, st_lcv, st_oof;

  wire nonfas  = frm_stb & ~frm_is_fas;
  wire clr_st  = reg_rd & reg_sel;
  wire set_oof = en_oof & (oof_lvl ^ oof_q);
  wire set_mf  = en_mf & (mfyel_lvl ^ mf_q);
  wire set_lcv = en_lcv & lcv_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_a <= 1'b0;
      rai_q  <= 1'b0;
    end else if (nonfas) begin
      last_a <= frm_a_bit;
      if (frm_a_bit && last_a)        rai_q <= 1'b1;
      else if (!frm_a_bit && !last_a) rai_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {en_mf, en_rsv, en_lcv, en_oof} <= '0;
    end else if (reg_wr && !reg_sel) begin
      en_mf  <= reg_wdata[B_MF];
      en_rsv <= reg_wdata[B_RSV];
      en_lcv <= reg_wdata[B_LCV];
      en_oof <= reg_wdata[B_OOF];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oof_q <= 1'b0;
      mf_q  <= 1'b0;
      {st_mf, st_lcv, st_oof} <= '0;
    end else begin
      oof_q  <= oof_lvl;
      mf_q   <= mfyel_lvl;
      st_oof <= set_oof | (st_oof & ~clr_st);
      st_mf  <= set_mf  | (st_mf  & ~clr_st);
      st_lcv <= set_lcv | (st_lcv & ~clr_st);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      reg_rdata[B_MF]  = st_mf;
      reg_rdata[B_LCV] = st_lcv;
      reg_rdata[B_OOF] = st_oof;
    end else begin
      reg_rdata[B_RAI] = rai_q;
      reg_rdata[B_MF]  = en_mf;
      reg_rdata[B_RSV] = en_rsv;
      reg_rdata[B_LCV] = en_lcv;
      reg_rdata[B_OOF] = en_oof;
    end
  end

  assign rai_state = rai_q;
  assign irq       = st_mf | st_lcv | st_oof;

  p_declare_r1: assert property (@(posedge clk) disable iff (!rst_n)
    nonfas && frm_a_bit && last_a |=> rai_state);
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    nonfas && !frm_a_bit && !last_a |=> !rai_state);
  p_fas_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !nonfas |=> $stable(rai_state) && $stable(last_a));
  p_oof_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_oof && (oof_lvl != oof_q) |=> reg_sel || reg_rdata[B_OOF] || irq);
  p_mf_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_mf && (mfyel_lvl != mf_q) |=> irq);
  p_lcv_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_lcv && lcv_pulse |=> irq);
  p_rd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_st && !set_oof && !set_mf && !set_lcv |=> !irq);
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_st |=> irq);
endmodule

// File: tb/e1_rai_irq_tb.sv
module e1_rai_irq_tb;
  logic clk = 0, rst_n = 0;
  logic frm_stb = 0, frm_is_fas = 0, frm_a_bit = 0;
  logic oof_lvl = 0, mfyel_lvl = 0, lcv_pulse = 0;
  logic reg_sel = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic rai_state, irq;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string req_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  e1_rai_irq #(.DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .frm_is_fas(frm_is_fas),
    .frm_a_bit(frm_a_bit), .oof_lvl(oof_lvl), .mfyel_lvl(mfyel_lvl),
    .lcv_pulse(lcv_pulse), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rai_state(rai_state), .irq(irq));

  always @(negedge clk) begin
    if (reg_rd && exp_q.size() > 0) begin
      logic [7:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s: read sel=%0d got %h expected %h", r, reg_sel, reg_rdata, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic act, input logic exp, input string r);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", r, act, exp);
    end
  endtask

  task automatic frame(input logic fas, input logic a);
    frm_stb = 1; frm_is_fas = fas; frm_a_bit = a;
    tick();
    frm_stb = 0;
  endtask

  task automatic wr_en(input logic [7:0] v);
    reg_sel = 0; reg_wr = 1; reg_wdata = v;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd(input logic sel, input logic [7:0] e, input string r);
    reg_sel = sel; reg_rd = 1;
    exp_q.push_back(e); req_q.push_back(r);
    tick();
    reg_rd = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk(rai_state, 0, "R1 reset");
    chk(irq, 0, "R9 reset");
    rd(0, 8'h00, "R4 reset");
    wr_en(8'hFF);
    rd(0, 8'h3C, "R4 ro/reserved");
    wr_en(8'h2C);
    rd(0, 8'h2C, "R4 readback");

    frame(0, 1); chk(rai_state, 0, "R1 single");
    frame(1, 0); chk(rai_state, 0, "R3 fas");
    frame(0, 1); chk(rai_state, 1, "R1 declare");
    frame(1, 0); frame(1, 0); chk(rai_state, 1, "R3 fas hold");
    frame(0, 0); chk(rai_state, 1, "R2 single");
    frame(1, 1); chk(rai_state, 1, "R3 fas");
    frame(0, 0); chk(rai_state, 0, "R2 clear");
    frame(0, 1); frame(0, 0); frame(0, 1);
    chk(rai_state, 0, "R1 alternating");
    frame(0, 1); chk(rai_state, 1, "R1 declare2");
    rd(0, 8'hAC, "R4 rai bit7");
    frame(0, 0); frame(0, 0); chk(rai_state, 0, "R2 clear2");
    chk(irq, 0, "R9 idle");

    oof_lvl = 1; tick();
    chk(irq, 1, "R9 set");
    rd(1, 8'h04, "R5 rise");
    chk(irq, 0, "R8 cleared");
    oof_lvl = 0; tick();
    rd(1, 8'h04, "R5 fall");
    mfyel_lvl = 1; tick();
    rd(1, 8'h20, "R6 rise");
    mfyel_lvl = 0; tick();
    rd(1, 8'h20, "R6 fall");
    lcv_pulse = 1; tick(); lcv_pulse = 0; tick(); tick();
    chk(irq, 1, "R7 sticky");
    rd(1, 8'h08, "R7 lcv");
    rd(1, 8'h00, "R8 empty");

    wr_en(8'h00);
    oof_lvl = 1; tick(); tick();
    chk(irq, 0, "R5 masked");
    rd(1, 8'h00, "R5 masked");
    oof_lvl = 0; tick();
    wr_en(8'h2C);

    lcv_pulse = 1;
    rd(1, 8'h00, "R8 same-cycle");
    lcv_pulse = 0;
    chk(irq, 1, "R8 event kept");
    rd(1, 8'h08, "R8 event kept");

    oof_lvl = 1; lcv_pulse = 1; tick(); lcv_pulse = 0;
    rd(1, 8'h0C, "R8 combined");
    chk(irq, 0, "R9 after read");

    tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule